// File: doc/BRIEF.md
# Multi-word instruction fetch decoder

This block sits between an instruction word stream and the control logic of a small 16-bit processor. Words arrive one per handshake on a valid/ready input. The opcode in the first word of each instruction tells the block whether one, two or three words make up the instruction. The block collects the extra words and then presents one decoded record on a valid/ready output. The record holds the opcode, the two 4-bit register or flag fields, a 16-bit constant or local address when there is one, a 24-bit global address when there is one, the instruction length, and a flag that marks an undefined opcode.

A global address arrives in two words, high word first. The block keeps the low byte of the high word and places it above the full low word. While a finished record waits for the downstream side, the block takes no new words. This means the record cannot change under the consumer and no input word can be lost. A synchronous reset drops any instruction that is only partly collected.

Top module: `instr_word_assembler`

## Requirements
- R1: While `rst` is high at a clock edge, the collected state is cleared. After that edge `out_valid` is 0 and `in_ready` is 1, and the next accepted word is treated as the first word of a new instruction.
- R2: The output opcode is bits 15:8 of the first word. `out_rd` is bits 7:4 and `out_rs` is bits 3:0 of the same word.
- R3: The opcode sets the length. Two words: 0x08, 0x0C, 0x10, 0x80 to 0x89, 0xC0 and 0xC4. Three words: 0x09, 0x11, 0xC1 and 0xC5. One word: all other opcodes. `out_len` carries the length as 1, 2 or 3.
- R4: For a two-word instruction, `out_imm` equals the second word and `out_gaddr` is 0.
- R5: For a three-word instruction, `out_gaddr` is bits 7:0 of the second word followed by all 16 bits of the third word, and `out_imm` is 0.
- R6: For a one-word instruction, `out_imm` and `out_gaddr` are 0.
- R7: `out_illegal` is 1 exactly when the opcode is none of the defined ones. The defined opcodes are the two-word and three-word sets of R3 plus 0x0A, 0x12, 0x20, 0x40 to 0x43, 0x45 to 0x48, 0x55 to 0x57, 0x65, 0x75, 0xC2, 0xC8, 0xC9, 0xD0, 0xD1, 0xE0 to 0xE3 and 0xFF. An illegal opcode has length 1.
- R8: While `out_valid` is 1, `in_ready` is 0. The record stays unchanged until a cycle in which `out_ready` is 1. A word offered during that time is neither consumed nor lost.
- R9: `out_valid` rises at the clock edge that accepts the last word of an instruction. Idle cycles between the words of an instruction do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 16 | Instruction stream word |
| out_valid | output | 1 | Decoded record is available |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Opcode field |
| out_rd | output | 4 | Destination register, flag or bit index field |
| out_rs | output | 4 | Source register field |
| out_imm | output | 16 | Constant or local address |
| out_gaddr | output | 24 | Global address |
| out_len | output | 2 | Instruction length in words |
| out_illegal | output | 1 | Opcode is undefined |

## Verification
Each word is accepted at the rising edge that sees both `in_valid` and `in_ready` high. The record is registered at the edge that takes the final word, so the bench looks for it at the very next falling edge and logs a failure if it has to wait any longer. Once the record is handed over with `out_ready`, `in_ready` comes back one edge later. The bench therefore offers words only at falling edges, after it has read `in_ready` there. Every opcode from 0x00 to 0xFF is tried, some with idle gaps between words. Separate passes stall the output while a word waits at the input, and reset the block halfway through a three-word instruction.

// File: rtl/iwa_pkg.sv
package iwa_pkg;

   // Instruction length in words; the numeric value is the word count.
   typedef enum logic [1:0] {
      LEN_ONE   = 2'd1,
      LEN_TWO   = 2'd2,
      LEN_THREE = 2'd3
   } ilen_e;

   // Number of words an instruction may carry after its opcode word.
   localparam int unsigned MAX_EXT_WORDS = 2;

endpackage

// File: rtl/iwa_len_classify.sv
module iwa_len_classify
   import iwa_pkg::*;
#(
   parameter int unsigned OP_W = 8
) (
   input  logic [OP_W-1:0] opcode,
   output ilen_e           len,
   output logic            illegal
);

   generate
      if (OP_W != 8) begin : g_bad_op_w
         $error("iwa_len_classify: opcode table is defined for 8-bit opcodes");
      end
   endgenerate

   always_comb begin
      len     = LEN_ONE;
      illegal = 1'b0;
      case (opcode) inside
         // two words: opcode word plus constant or local address
         8'h08, 8'h0C, 8'h10, [8'h80:8'h89], 8'hC0, 8'hC4:
            len = LEN_TWO;
         // three words: opcode, address high word, address low word
         8'h09, 8'h11, 8'hC1, 8'hC5:
            len = LEN_THREE;
         // defined single-word operations
         8'h0A, 8'h12, 8'h20,
         [8'h40:8'h43], [8'h45:8'h48], [8'h55:8'h57], 8'h65, 8'h75,
         8'hC2, 8'hC8, 8'hC9, 8'hD0, 8'hD1, [8'hE0:8'hE3], 8'hFF:
            len = LEN_ONE;
         default:
            illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/iwa_collector.sv
module iwa_collector
   import iwa_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned N_EXT  = MAX_EXT_WORDS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   input  ilen_e             first_len,
   input  logic              first_illegal,
   output logic              rec_valid,
   input  logic              rec_ready,
   output logic [WORD_W-1:0] word0_q,
   output logic [WORD_W-1:0] ext_q [N_EXT],
   output ilen_e             len_q,
   output logic              illegal_q
);

   localparam int unsigned CNT_W = $clog2(N_EXT + 1);

   generate
      if (N_EXT != 2) begin : g_bad_n_ext
         $error("iwa_collector: length encoding supports exactly two extension words");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;   // words of the current instruction already taken
   logic             vld_q;
   logic             take;

   assign in_ready  = !vld_q;
   assign take      = in_valid && in_ready;
   assign rec_valid = vld_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q     <= 1'b0;
         cnt_q     <= '0;
         len_q     <= LEN_ONE;
         illegal_q <= 1'b0;
         word0_q   <= '0;
      end else begin
         if (vld_q && rec_ready) begin
            vld_q <= 1'b0;
         end
         if (take) begin
            if (cnt_q == '0) begin
               word0_q   <= in_word;
               len_q     <= first_len;
               illegal_q <= first_illegal;
               if (first_len == LEN_ONE) begin
                  vld_q <= 1'b1;
               end else begin
                  cnt_q <= CNT_W'(1);
               end
            end else if (cnt_q == CNT_W'(1)) begin
               if (len_q == LEN_TWO) begin
                  vld_q <= 1'b1;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= CNT_W'(2);
               end
            end else begin
               vld_q <= 1'b1;
               cnt_q <= '0;
            end
         end
      end
   end

   // one holding register per extension slot
   generate
      for (genvar k = 0; k < N_EXT; k++) begin : g_ext
         always_ff @(posedge clk) begin
            if (rst) begin
               ext_q[k] <= '0;
            end else if (take && cnt_q == CNT_W'(k + 1)) begin
               ext_q[k] <= in_word;
            end
         end
      end
   endgenerate

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(N_EXT));                                         // R3

   AST_NO_PARTIAL_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
      vld_q |-> cnt_q == '0);                                          // R8

   AST_TWO_WORD_ENDS: assert property (@(posedge clk) disable iff (rst)
      take && cnt_q == CNT_W'(1) && len_q == LEN_TWO |=> vld_q);      // R9

endmodule

// File: rtl/instr_word_assembler.sv
module instr_word_assembler
   import iwa_pkg::*;
#(
   parameter int unsigned WORD_W  = 16,
   parameter int unsigned OP_W    = 8,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned GADDR_W = 24
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [WORD_W-1:0]  in_word,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [OP_W-1:0]    out_opcode,
   output logic [FIELD_W-1:0] out_rd,
   output logic [FIELD_W-1:0] out_rs,
   output logic [WORD_W-1:0]  out_imm,
   output logic [GADDR_W-1:0] out_gaddr,
   output logic [1:0]         out_len,
   output logic               out_illegal
);

   localparam int unsigned N_FIELD = (WORD_W - OP_W) / FIELD_W;
   localparam int unsigned HI_KEEP = GADDR_W - WORD_W;
   localparam int unsigned N_EXT   = MAX_EXT_WORDS;

   generate
      if (WORD_W != OP_W + N_FIELD * FIELD_W || N_FIELD != 2) begin : g_bad_fields
         $error("instr_word_assembler: word must hold opcode and two fields");
      end
      if (GADDR_W <= WORD_W || GADDR_W > 2 * WORD_W) begin : g_bad_gaddr
         $error("instr_word_assembler: global address must span two words");
      end
   endgenerate

   ilen_e             cls_len;
   logic              cls_illegal;
   logic [WORD_W-1:0] word0_q;
   logic [WORD_W-1:0] ext_q [N_EXT];
   ilen_e             len_q;
   logic              illegal_q;

   iwa_len_classify #(.OP_W(OP_W)) u_cls (
      .opcode  (in_word[WORD_W-1 -: OP_W]),
      .len     (cls_len),
      .illegal (cls_illegal)
   );

   iwa_collector #(.WORD_W(WORD_W), .N_EXT(N_EXT)) u_col (
      .clk           (clk),
      .rst           (rst),
      .in_valid      (in_valid),
      .in_ready      (in_ready),
      .in_word       (in_word),
      .first_len     (cls_len),
      .first_illegal (cls_illegal),
      .rec_valid     (out_valid),
      .rec_ready     (out_ready),
      .word0_q       (word0_q),
      .ext_q         (ext_q),
      .len_q         (len_q),
      .illegal_q     (illegal_q)
   );

   // operand fields of the opcode word, lowest first
   logic [FIELD_W-1:0] field [N_FIELD];
   generate
      for (genvar f = 0; f < N_FIELD; f++) begin : g_field
         assign field[f] = word0_q[f*FIELD_W +: FIELD_W];
      end
   endgenerate

   assign out_opcode  = word0_q[WORD_W-1 -: OP_W];
   assign out_rs      = field[0];
   assign out_rd      = field[1];
   assign out_len     = len_q;
   assign out_illegal = illegal_q;
   assign out_imm     = (len_q == LEN_TWO)   ? ext_q[0] : '0;
   assign out_gaddr   = (len_q == LEN_THREE) ? {ext_q[0][HI_KEEP-1:0], ext_q[1]} : '0;

   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> !out_valid && in_ready);                                  // R1

   AST_RECORD_HELD: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_rd)
         && $stable(out_rs) && $stable(out_imm) && $stable(out_gaddr)
         && $stable(out_len));                                           // R8

   AST_ILLEGAL_SHORT: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_illegal |-> out_len == 2'd1 && out_gaddr == '0);  // R7

   AST_GLOBAL_LONG: assert property (@(posedge clk) disable iff (rst)
      out_valid && (out_opcode == 8'h09 || out_opcode == 8'h11 || out_opcode == 8'hC1
         || out_opcode == 8'hC5) |-> out_len == 2'd3 && out_imm == '0);  // R5

   AST_NOP_BARE: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_opcode == 8'hFF |-> out_len == 2'd1 && out_imm == '0
         && out_gaddr == '0 && !out_illegal);                            // R6

endmodule

// File: tb/instr_word_assembler_test.sv
`timescale 1ns/1ps
module instr_word_assembler_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_word = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_opcode;
   logic [3:0]  out_rd, out_rs;
   logic [15:0] out_imm;
   logic [23:0] out_gaddr;
   logic [1:0]  out_len;
   logic        out_illegal;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   instr_word_assembler uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
      .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
      .out_rd(out_rd), .out_rs(out_rs), .out_imm(out_imm), .out_gaddr(out_gaddr),
      .out_len(out_len), .out_illegal(out_illegal)
   );

   function automatic int exp_len(input logic [7:0] op);
      case (op) inside
         8'h08, 8'h0C, 8'h10, [8'h80:8'h89], 8'hC0, 8'hC4: return 2;
         8'h09, 8'h11, 8'hC1, 8'hC5:                        return 3;
         default:                                           return 1;
      endcase
   endfunction

   function automatic bit exp_illegal(input logic [7:0] op);
      if (exp_len(op) != 1) return 1'b0;
      case (op) inside
         8'h0A, 8'h12, 8'h20, [8'h40:8'h43], [8'h45:8'h48], [8'h55:8'h57], 8'h65, 8'h75,
         8'hC2, 8'hC8, 8'hC9, 8'hD0, 8'hD1, [8'hE0:8'hE3], 8'hFF: return 1'b0;
         default: return 1'b1;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // offer one word at a falling edge; return after the accepting rising edge
   task automatic send_word(input logic [15:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   // wait for the record and check it, then hand it over
   task automatic take_record(input logic [7:0] op, input logic [3:0] rd, input logic [3:0] rs,
                              input logic [15:0] e1, input logic [15:0] e2);
      int waited = 0;
      int len;
      logic [15:0] ximm;
      logic [23:0] xga;
      len  = exp_len(op);
      ximm = (len == 2) ? e1 : 16'h0;
      xga  = (len == 3) ? {e1[7:0], e2} : 24'h0;
      @(negedge clk);
      while (!out_valid && waited < 20) begin
         waited++;
         @(negedge clk);
      end
      chk(waited == 0, "R9 record due one edge after last word", waited, 0);
      chk(out_opcode == op, "R2 opcode", out_opcode, op);
      chk(out_rd == rd, "R2 rd field", out_rd, rd);
      chk(out_rs == rs, "R2 rs field", out_rs, rs);
      chk(out_len == 2'(len), "R3 length", out_len, len);
      chk(out_illegal == exp_illegal(op), "R7 illegal flag", out_illegal, exp_illegal(op));
      if (len == 2)
         chk(out_imm == ximm && out_gaddr == 0, "R4 two-word operand", {out_imm, out_gaddr[15:0]}, {ximm, 16'h0});
      else if (len == 3)
         chk(out_gaddr == xga && out_imm == 0, "R5 global address", {out_gaddr, out_imm[7:0]}, {xga, 8'h0});
      else
         chk(out_imm == 0 && out_gaddr == 0, "R6 one-word operands", {out_imm, out_gaddr[15:0]}, 0);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic run_instr(input logic [7:0] op, input logic [3:0] rd, input logic [3:0] rs,
                            input logic [15:0] e1, input logic [15:0] e2, input bit gap);
      int len;
      len = exp_len(op);
      send_word({op, rd, rs});
      if (len > 1) begin
         if (gap) repeat (2) @(negedge clk);
         send_word(e1);
      end
      if (len > 2) begin
         if (gap) @(negedge clk);
         send_word(e2);
      end
      take_record(op, rd, rs, e1, e2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
      chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
      rst = 1'b0;

      // full opcode sweep
      for (int i = 0; i < 256; i++) begin
         logic [7:0] op;
         op = 8'(i);
         run_instr(op, op[3:0] ^ 4'h5, ~op[7:4], 16'({op, ~op}) ^ 16'h3C5A,
                   16'(i * 97) + 16'h1234, op[1]);
      end

      // back-pressure: record held, waiting word not taken
      send_word(16'hFF00);
      @(negedge clk);
      chk(out_valid == 1'b1, "R8 record present", out_valid, 1);
      in_valid = 1'b1;
      in_word  = 16'h4537;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(in_ready == 1'b0, "R8 input blocked while held", in_ready, 0);
         chk(out_opcode == 8'hFF && out_valid, "R8 record stable", {out_valid, out_opcode}, 9'h1FF);
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R8 released", {out_valid, in_ready}, 2'b01);
      @(posedge clk);
      #1 in_valid = 1'b0;
      take_record(8'h45, 4'h3, 4'h7, 16'h0, 16'h0);

      // reset in the middle of a three-word instruction
      send_word(16'h0910);
      send_word(16'h00AB);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 mid-instruction reset", {out_valid, in_ready}, 2'b01);
      send_word(16'h2021);
      take_record(8'h20, 4'h2, 4'h1, 16'h0, 16'h0);

      // three-word with high byte extremes
      run_instr(8'hC5, 4'hF, 4'h0, 16'hFFFF, 16'h0000, 1'b0);
      run_instr(8'hC1, 4'h0, 4'hF, 16'h5A00, 16'hFFFF, 1'b1);

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule